// File: doc/BRIEF.md
# Maskable Interrupt Controller with Fixed Vector

This block collects seven interrupt sources and presents them to a CPU core as one request line. Two sources sit close to the core: an edge-triggered interrupt pin and a change detector on four port pins. The other five belong to a peripheral group: three timers, a serial unit and a capture/compare unit. Every source has a sticky pending flag and its own enable bit. A group enable gates the peripheral sources. A global enable gates everything.

The core raises `irq_ack` in a cycle where `irq_req` is high. The controller then drops the global enable. In the next cycle it pulses `push_ret`, which tells the core to stack its return address, and `pc_load`, which loads the program counter from the constant `pc_vector`. The return-from-interrupt strobe sets the global enable again. Hardware never clears a pending flag. Software clears a flag by writing a one to it over a small register bus.

The port-change detector compares the four port pins with a reference copy. That copy is taken at reset and again on every `port_rd` strobe. Any difference raises the change flag.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset, all four registers read 0, and `irq_req`, `push_ret` and `pc_load` are low.
- R2: Control bit 2 selects the edge of `ext_pin`: 1 for rising, 0 for falling. A selected edge sets core flag bit 0 at the clock edge where the new pin level is first sampled. The opposite edge leaves the flag unchanged.
- R3: Core flag bit 1 is set in every cycle where `port_hi` differs from the reference value. The reference is loaded from `port_hi` at reset and on each cycle with `port_rd` high.
- R4: A high bit of `periph_evt` sets the peripheral flag with the same index. The bit order is timer0 (0), timer1 (1), timer2 (2), serial (3), capture/compare (4).
- R5: Writing a one to a flag bit (address 1 or 3) clears that bit, and writing a zero leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R6: With the global enable (control bit 0) set, `irq_req` is high when a core flag is set and its enable is also set. The pin flag's enable is control bit 3 and the change flag's enable is control bit 4. The peripheral group enable does not matter for these two flags.
- R7: A peripheral flag raises `irq_req` only when its enable bit (address 2, same index) is set, the group enable (control bit 1) is set and the global enable is set.
- R8: `irq_ack` while `irq_req` is high has three effects. It clears the global enable. It drops `irq_req` in the next cycle. It gives a one-cycle pulse on `push_ret` and `pc_load` in that next cycle. `pc_vector` always reads 0x0004. An `irq_ack` while `irq_req` is low has no effect.
- R9: `irq_ret` sets the global enable. An accepted `irq_ack` in the same cycle wins over `irq_ret`, and `irq_ret` wins over a bus write to the control register.
- R10: The register addresses are: 0 for control (bits 4:0), 1 for core flags (bits 1:0), 2 for peripheral enables (bits 4:0) and 3 for peripheral flags (bits 4:0). Unused read bits are 0, and `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| ext_pin | input | 1 | External interrupt pin |
| port_hi | input | 4 | Port pins 7 to 4 being watched for change |
| port_rd | input | 1 | Port read strobe, reloads the change reference |
| periph_evt | input | 5 | Peripheral event pulses |
| irq_ack | input | 1 | Core accepts the request |
| irq_ret | input | 1 | Core returns from interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| push_ret | output | 1 | Push return address, one cycle |
| pc_load | output | 1 | Load program counter from vector, one cycle |
| pc_vector | output | 13 | Fixed interrupt vector |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both. In the first, a peripheral event pulse arrives in the same cycle as a write-one-to-clear of that flag. In the second, a return strobe coincides with an accepted acknowledge or with a control-register write.

To set these up, the bench drives both inputs in the same clock period. It then reads the register back to see which side won. The outcome is judged against R5 and R9, and a cycle-by-cycle behavioural model checks the request line and the vector pulses on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DW     = 8;
    localparam int AW     = 2;
    localparam int N_CORE = 2;
    localparam int N_PERI = 5;

    // core flag indices
    localparam int CORE_PIN = 0;
    localparam int CORE_CHG = 1;

    typedef enum logic [AW-1:0] {
        RA_CTL  = 2'd0,
        RA_CFLG = 2'd1,
        RA_PEN  = 2'd2,
        RA_PFLG = 2'd3
    } reg_addr_e;

    // packed so that gie is bit 0
    typedef struct packed {
        logic chg_en;
        logic pin_en;
        logic edge_rise;
        logic peie;
        logic gie;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [DW-1:0] zext_ctl(input ctl_t c);
        return {{(DW-CTL_W){1'b0}}, c};
    endfunction

    function automatic logic [DW-1:0] zext_core(input logic [N_CORE-1:0] v);
        return {{(DW-N_CORE){1'b0}}, v};
    endfunction

    function automatic logic [DW-1:0] zext_peri(input logic [N_PERI-1:0] v);
        return {{(DW-N_PERI){1'b0}}, v};
    endfunction

endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
    parameter int N_CHG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic             rise_sel_i,
    input  logic [N_CHG-1:0] port_i,
    input  logic             port_rd_i,
    output logic             pin_evt_o,
    output logic             chg_evt_o
);

    logic             pin_q;
    logic [N_CHG-1:0] ref_q;
    logic [N_CHG-1:0] diff;

    // reset captures the live levels so no spurious event follows reset
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= pin_i;
            ref_q <= port_i;
        end else begin
            pin_q <= pin_i;
            if (port_rd_i) begin
                ref_q <= port_i;
            end
        end
    end

    for (genvar i = 0; i < N_CHG; i++) begin : g_cmp
        assign diff[i] = port_i[i] ^ ref_q[i];
    end

    always_comb begin
        if (rise_sel_i) begin
            pin_evt_o = pin_i & ~pin_q;
        end else begin
            pin_evt_o = ~pin_i & pin_q;
        end
    end

    assign chg_evt_o = |diff;

    assert_ref_reload_R3: assert property (@(posedge clk) disable iff (rst)
        port_rd_i |=> (ref_q == $past(port_i)));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else if (set_i[i]) begin
                q <= 1'b1;
            end else if (clr_i[i]) begin
                q <= 1'b0;
            end
        end

        assign flag_o[i] = q;

        assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_o[i]);

        assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
            (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
    end

endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_pkg::*;
#(
    parameter int PC_W   = 13,
    parameter int VECTOR = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_ctl_i,
    input  ctl_t            wdata_i,
    input  logic            ack_i,
    input  logic            ret_i,
    input  logic            pend_i,
    output ctl_t            ctl_o,
    output logic            irq_req_o,
    output logic            push_ret_o,
    output logic            pc_load_o,
    output logic [PC_W-1:0] pc_vec_o
);

    ctl_t ctl_q;
    ctl_t ctl_d;
    logic take;
    logic vec_q;

    assign irq_req_o = ctl_q.gie & pend_i;
    assign take      = ack_i & irq_req_o;

    // priority: acceptance over return over bus write
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl_i) begin
            ctl_d = wdata_i;
        end
        if (ret_i) begin
            ctl_d.gie = 1'b1;
        end
        if (take) begin
            ctl_d.gie = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            vec_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            vec_q <= take;
        end
    end

    assign ctl_o      = ctl_q;
    assign push_ret_o = vec_q;
    assign pc_load_o  = vec_q;
    assign pc_vec_o   = PC_W'(VECTOR);

    assert_ack_clears_gie_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_req_o) |=> !ctl_o.gie);

    assert_single_load_R8: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !pc_load_o);

    assert_ret_sets_gie_R9: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !ack_i) |=> ctl_o.gie);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int PC_W   = 13,
    parameter int VECTOR = 4,
    parameter int N_CHG  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              ext_pin,
    input  logic [N_CHG-1:0]  port_hi,
    input  logic              port_rd,
    input  logic [N_PERI-1:0] periph_evt,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req,
    output logic              push_ret,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_vector
);

    reg_addr_e          addr;
    ctl_t               ctl;
    logic               pin_evt;
    logic               chg_evt;
    logic [N_CORE-1:0]  core_set;
    logic [N_CORE-1:0]  core_clr;
    logic [N_CORE-1:0]  core_flg;
    logic [N_CORE-1:0]  core_en;
    logic [N_PERI-1:0]  peri_clr;
    logic [N_PERI-1:0]  peri_flg;
    logic [N_PERI-1:0]  peri_en_q;
    logic               pend;
    logic               unused_wdata;

    assign addr         = reg_addr_e'(bus_addr);
    assign unused_wdata = &{1'b0, bus_wdata[DW-1:CTL_W]};

    irq_src_detect #(.N_CHG(N_CHG)) u_src (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (ext_pin),
        .rise_sel_i(ctl.edge_rise),
        .port_i    (port_hi),
        .port_rd_i (port_rd),
        .pin_evt_o (pin_evt),
        .chg_evt_o (chg_evt)
    );

    always_comb begin
        core_set           = '0;
        core_set[CORE_PIN] = pin_evt;
        core_set[CORE_CHG] = chg_evt;
        core_en            = '0;
        core_en[CORE_PIN]  = ctl.pin_en;
        core_en[CORE_CHG]  = ctl.chg_en;
    end

    assign core_clr = (bus_wr && addr == RA_CFLG) ? bus_wdata[N_CORE-1:0] : '0;
    assign peri_clr = (bus_wr && addr == RA_PFLG) ? bus_wdata[N_PERI-1:0] : '0;

    irq_flag_bank #(.N(N_CORE)) u_core_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (core_set),
        .clr_i (core_clr),
        .flag_o(core_flg)
    );

    irq_flag_bank #(.N(N_PERI)) u_peri_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (periph_evt),
        .clr_i (peri_clr),
        .flag_o(peri_flg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            peri_en_q <= '0;
        end else if (bus_wr && addr == RA_PEN) begin
            peri_en_q <= bus_wdata[N_PERI-1:0];
        end
    end

    // two-level gating: peripheral group also needs peie
    assign pend = (|(core_flg & core_en)) | (ctl.peie & (|(peri_flg & peri_en_q)));

    irq_accept #(.PC_W(PC_W), .VECTOR(VECTOR)) u_accept (
        .clk       (clk),
        .rst       (rst),
        .wr_ctl_i  (bus_wr && addr == RA_CTL),
        .wdata_i   (ctl_t'(bus_wdata[CTL_W-1:0])),
        .ack_i     (irq_ack),
        .ret_i     (irq_ret),
        .pend_i    (pend),
        .ctl_o     (ctl),
        .irq_req_o (irq_req),
        .push_ret_o(push_ret),
        .pc_load_o (pc_load),
        .pc_vec_o  (pc_vector)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (addr)
                RA_CTL:  bus_rdata = zext_ctl(ctl);
                RA_CFLG: bus_rdata = zext_core(core_flg);
                RA_PEN:  bus_rdata = zext_peri(peri_en_q);
                RA_PFLG: bus_rdata = zext_peri(peri_flg);
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_pin_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl.edge_rise && $rose(ext_pin)) |=> core_flg[CORE_PIN]);

    assert_req_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> !irq_req);

    assert_req_needs_gie_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ctl.gie);

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/100ps
module sim_irq_vector_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        ext_pin = 1'b1;
    logic [3:0]  port_hi = 4'h0;
    logic        port_rd = 1'b0;
    logic [4:0]  periph_evt = 5'd0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic        push_ret;
    logic        pc_load;
    logic [12:0] pc_vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .port_hi(port_hi), .port_rd(port_rd),
        .periph_evt(periph_evt), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .push_ret(push_ret), .pc_load(pc_load),
        .pc_vector(pc_vector)
    );

    // ---------------- behavioural reference model ----------------
    int m_ctl, m_cflg, m_pen, m_pflg, m_prev, m_ref, m_vec;

    function automatic int model_req();
        bit core_hit = (m_cflg & ((((m_ctl >> 4) & 1) << 1) | ((m_ctl >> 3) & 1))) != 0;
        bit peri_hit = ((m_ctl & 2) != 0) && ((m_pflg & m_pen) != 0);
        return ((m_ctl & 1) != 0 && (core_hit || peri_hit)) ? 1 : 0;
    endfunction

    function automatic int model_read(input int a);
        case (a)
            0: return m_ctl;
            1: return m_cflg;
            2: return m_pen;
            default: return m_pflg;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctl = 0; m_cflg = 0; m_pen = 0; m_pflg = 0; m_vec = 0;
            m_prev = ext_pin; m_ref = port_hi;
        end else begin
            int acc, pin_e, chg_e, clr;
            acc   = (irq_ack && model_req() == 1) ? 1 : 0;
            pin_e = ((m_ctl & 4) != 0) ? (ext_pin && m_prev == 0) : (!ext_pin && m_prev == 1);
            chg_e = (port_hi != m_ref[3:0]) ? 1 : 0;
            if (bus_wr && bus_addr == 0) m_ctl = bus_wdata & 8'h1F;
            if (irq_ret) m_ctl = m_ctl | 1;
            if (acc == 1) m_ctl = m_ctl & ~1;
            clr = (bus_wr && bus_addr == 1) ? (bus_wdata & 3) : 0;
            m_cflg = (m_cflg & ~clr) | (chg_e << 1) | pin_e;
            if (bus_wr && bus_addr == 2) m_pen = bus_wdata & 8'h1F;
            clr = (bus_wr && bus_addr == 3) ? (bus_wdata & 8'h1F) : 0;
            m_pflg = (m_pflg & ~clr) | periph_evt;
            m_prev = ext_pin;
            if (port_rd) m_ref = port_hi;
            m_vec = acc;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compared on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R6,R7 irq_req vs model", irq_req, model_req());
            check("R8 push_ret vs model", push_ret, m_vec);
            check("R8 pc_load vs model", pc_load, m_vec);
            check("R8 pc_vector", pc_vector, 4);
            if (bus_rd) check("R10 readback vs model", bus_rdata, model_read(bus_addr));
            else        check("R10 idle read zero", bus_rdata, 0);
        end
    end

    // ---------------- stimulus tasks (entered at negedge+1) ----------------
    task automatic idle();
        @(negedge clk); #1;
    endtask

    task automatic wr(input int a, input int d);
        bus_wr = 1'b1; bus_addr = a[1:0]; bus_wdata = d[7:0];
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        bus_rd = 1'b1; bus_addr = a[1:0];
        #0.5;
        check(tag, bus_rdata, exp);
        @(negedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk); #1;
        irq_ack = 1'b0;
    endtask

    task automatic ret_pulse();
        irq_ret = 1'b1;
        @(negedge clk); #1;
        irq_ret = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 irq_req after reset", irq_req, 0);
        check("R1 push_ret after reset", push_ret, 0);
        for (int a = 0; a < 4; a++) rd(a, 0, "R1 register reset value");

        // R2 falling edge with default select
        ext_pin = 1'b0; idle();
        rd(1, 8'h01, "R2 falling edge sets pin flag");
        wr(0, 8'h04);
        wr(1, 8'h01);
        rd(1, 8'h00, "R5 write one clears pin flag");
        ext_pin = 1'b1; idle();
        rd(1, 8'h01, "R2 rising edge sets pin flag");
        wr(1, 8'h01);
        ext_pin = 1'b0; idle();
        rd(1, 8'h00, "R2 opposite edge ignored");

        // R3 port change
        port_hi = 4'hA; idle();
        rd(1, 8'h02, "R3 port mismatch sets change flag");
        wr(1, 8'h02);
        rd(1, 8'h02, "R5 set wins while mismatch persists");
        port_rd = 1'b1; idle(); port_rd = 1'b0;
        wr(1, 8'h02);
        rd(1, 8'h00, "R3 reference reloaded on port read");

        // R4 / R5 peripheral flags
        periph_evt = 5'b10100; idle(); periph_evt = 5'd0;
        rd(3, 8'h14, "R4 peripheral events set flags");
        wr(3, 8'h04);
        rd(3, 8'h10, "R5 partial clear keeps other flags");
        periph_evt = 5'b10000; wr(3, 8'h10); periph_evt = 5'd0;
        rd(3, 8'h10, "R5 set and clear same cycle");

        // R7 two-level gating
        wr(2, 8'h10);
        rd(2, 8'h10, "R10 peripheral enable readback");
        check("R7 no request without gie", irq_req, 0);
        wr(0, 8'h05);
        check("R7 no request without peie", irq_req, 0);
        wr(0, 8'h07);
        check("R7 request with all enables", irq_req, 1);

        // R6 core source without peie
        wr(0, 8'h04);
        wr(3, 8'h10);
        ext_pin = 1'b1; idle();
        wr(0, 8'h0D);
        check("R6 pin source needs no peie", irq_req, 1);
        wr(0, 8'h05);
        check("R6 pin source masked", irq_req, 0);
        wr(0, 8'h0D);

        // R8 acceptance
        ack_pulse();
        check("R8 push_ret pulse", push_ret, 1);
        check("R8 pc_load pulse", pc_load, 1);
        check("R8 request dropped", irq_req, 0);
        check("R8 vector value", pc_vector, 13'h0004);
        idle();
        check("R8 pulse is one cycle", pc_load, 0);
        rd(0, 8'h0C, "R8 gie cleared on accept");
        ack_pulse();
        check("R8 ack without request ignored", push_ret, 0);

        // R9 return and priorities
        ret_pulse();
        rd(0, 8'h0D, "R9 return sets gie");
        check("R9 request back after return", irq_req, 1);
        irq_ret = 1'b1; ack_pulse(); irq_ret = 1'b0;
        check("R9 accept wins over return", push_ret, 1);
        rd(0, 8'h0C, "R9 gie stays clear");
        irq_ret = 1'b1; wr(0, 8'h0C); irq_ret = 1'b0;
        rd(0, 8'h0D, "R9 return wins over bus write");

        idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule